// File: doc/BRIEF.md
# Serial-Loaded DAC Control Interface

This block is the digital front end of a single-channel 16-bit voltage-output converter. A host writes 24-bit frames over a three-wire serial link: an active-low frame sync, a serial clock, and a data line. Each completed frame loads a 16-bit two's-complement data word and a 2-bit power mode. The block turns the data word into an unsigned, midscale-centred tap index for a resistor-string converter. It also decodes the power mode into four mutually exclusive output-stage controls: active drive, a light pulldown to ground, a weak pulldown to ground, and an open output.

All three serial pins are oversampled by the block's own clock through a synchronizer. Serial clock edges and frame-sync edges are then found as changes between successive synchronized samples. A frame counts only when exactly 24 falling serial-clock edges arrive while sync is low. If sync rises early, the frame is dropped and nothing changes. Once a frame has been taken, further clocking is ignored until sync has been high and falls again. A one-cycle strobe marks each accepted update.

Top module: `dac_frontend`

## Requirements
- R1: After reset the tap output is 0x8000 (signed code 0), the mode output is 00, only the drive control is high, and the strobe is low.
- R2: Bits arrive most-significant first. Of the 24 bits in a frame, the first 6 are ignored, the next 2 form the mode (bit 17 is the upper mode bit), and the last 16 are the data word (bit 15 first).
- R3: A pin level is captured on a rising clk edge. The data and mode outputs and the strobe reflect a completed frame right after the third rising edge that follows the edge which captured the 24th falling serial-clock edge.
- R4: If sync rises before the 24th falling serial-clock edge, the frame is discarded: the tap, the mode and the controls keep their values and no strobe is produced.
- R5: After a completed frame, falling serial-clock edges while sync stays low change nothing. A new frame starts only when sync falls after having been high.
- R6: The tap output equals the stored data word with its top bit inverted: data 0x8000 gives tap 0x0000, data 0x7FFF gives 0xFFFF, and data 0x1234 gives 0x9234.
- R7: Mode 00 raises only drive, 01 only the light (1 kΩ) pulldown, 10 only the weak (100 kΩ) pulldown, and 11 only the open control. Exactly one control is high at all times.
- R8: The strobe is high for exactly one clock cycle per accepted frame, in the same cycle in which the new values first appear, and at no other time.
- R9: A frame that selects a power-down mode still loads its data word: the tap output follows that word while the output stage is powered down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_n_i | input | 1 | Frame sync, active low |
| sclk_i | input | 1 | Serial clock; data is taken on its falling edge |
| din_i | input | 1 | Serial data, most-significant bit first |
| tap_o | output | 16 | Offset-binary tap index for the resistor string |
| pmode_o | output | 2 | Stored power mode |
| drive_en_o | output | 1 | Amplifier drives the output |
| pull_1k_o | output | 1 | Output tied to ground through the light load |
| pull_100k_o | output | 1 | Output tied to ground through the weak load |
| hiz_o | output | 1 | Output left open |
| update_o | output | 1 | One-cycle strobe on each accepted frame |

## Verification
The hardest states to reach from the pins are a frame that ends at the very last edge and sync held low after completion while the serial clock keeps running. In both cases a single edge separates a correct design from a faulty one. The stimulus task therefore takes an explicit count of falling edges for every frame. With it the bench sends full frames, frames cut off at 23 edges, bare sync pulses with no edges, and frames followed by six extra edges carrying ones. A behavioural model fed from the same pins predicts every output on every clock, so an edge that is shifted or lost shows up at once.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;

  localparam int PM_W = 2;

  typedef enum logic [PM_W-1:0] {
    PM_DRIVE   = 2'b00,
    PM_PULL1K  = 2'b01,
    PM_PULL100K = 2'b10,
    PM_OPEN    = 2'b11
  } pmode_e;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'b00,
    RX_SHIFT = 2'b01,
    RX_HOLD  = 2'b10
  } rx_state_e;

  typedef struct packed {
    logic drive;
    logic pull_lo;
    logic pull_hi;
    logic open;
  } ostage_t;

  // Output-stage decode: exactly one control per mode.
  function automatic ostage_t stage_for(input pmode_e m);
    ostage_t s;
    s = '0;
    unique case (m)
      PM_DRIVE:    s.drive   = 1'b1;
      PM_PULL1K:   s.pull_lo = 1'b1;
      PM_PULL100K: s.pull_hi = 1'b1;
      default:     s.open    = 1'b1;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/dac_fe_sync.sv
module dac_fe_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] now_o
);

  logic [STAGES-1:0][W-1:0] pipe;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= RST_VAL;
        else        pipe[g] <= pins_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= RST_VAL;
        else        pipe[g] <= pipe[g-1];
      end
    end
  end

  assign now_o = pipe[STAGES-1];

endmodule

// File: rtl/dac_fe_rx.sv
module dac_fe_rx
  import dac_fe_pkg::*;
#(
  parameter  int FRAME_W = 24,
  parameter  int KEEP_W  = 18,
  localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_n_i,
  input  logic              sclk_i,
  input  logic              din_i,
  output logic              sync_fall_o,
  output logic              sync_rise_o,
  output logic              sclk_fall_o,
  output logic              done_o,
  output logic              abort_o,
  output logic [KEEP_W-1:0] word_o,
  output logic [CNT_W-1:0]  cnt_o,
  output rx_state_e         state_o
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

  logic             sync_prev, sclk_prev;
  logic [KEEP_W-2:0] sh;
  rx_state_e        state;
  logic [CNT_W-1:0] cnt;

  // Edge events between successive synchronized samples.
  assign sync_fall_o = sync_prev & ~sync_n_i;
  assign sync_rise_o = ~sync_prev & sync_n_i;
  assign sclk_fall_o = sclk_prev & ~sclk_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_prev <= 1'b1;
      sclk_prev <= 1'b1;
    end else begin
      sync_prev <= sync_n_i;
      sclk_prev <= sclk_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RX_IDLE;
      cnt     <= '0;
      sh      <= '0;
      word_o  <= '0;
      done_o  <= 1'b0;
      abort_o <= 1'b0;
    end else begin
      done_o  <= 1'b0;
      abort_o <= 1'b0;
      unique case (state)
        RX_IDLE: begin
          if (sync_fall_o) begin
            state <= RX_SHIFT;
            cnt   <= '0;
            sh    <= '0;
          end
        end
        RX_SHIFT: begin
          if (sync_rise_o) begin
            state   <= RX_IDLE;
            cnt     <= '0;
            sh      <= '0;
            abort_o <= 1'b1;
          end else if (sclk_fall_o) begin
            sh  <= {sh[KEEP_W-3:0], din_i};
            cnt <= cnt + 1'b1;
            if (cnt == LAST_IDX) begin
              word_o <= {sh, din_i};
              done_o <= 1'b1;
              state  <= RX_HOLD;
            end
          end
        end
        RX_HOLD: begin
          if (sync_rise_o) begin
            state <= RX_IDLE;
            cnt   <= '0;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  assign cnt_o   = cnt;
  assign state_o = state;

endmodule

// File: rtl/dac_fe_regs.sv
module dac_fe_regs
  import dac_fe_pkg::*;
#(
  parameter  int DATA_W = 16,
  localparam int WORD_W = DATA_W + PM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [DATA_W-1:0] data_o,
  output pmode_e            mode_o,
  output logic              strobe_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o   <= '0;
      mode_o   <= PM_DRIVE;
      strobe_o <= 1'b0;
    end else begin
      strobe_o <= load_i;
      if (load_i) begin
        data_o <= word_i[DATA_W-1:0];
        mode_o <= pmode_e'(word_i[WORD_W-1:DATA_W]);
      end
    end
  end

endmodule

// File: rtl/dac_fe_outstage.sv
module dac_fe_outstage
  import dac_fe_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] data_i,
  input  pmode_e            mode_i,
  output logic [DATA_W-1:0] tap_o,
  output ostage_t           stage_o
);

  // Two's complement to offset binary: flip the sign bit.
  function automatic logic [DATA_W-1:0] offset_tap(input logic [DATA_W-1:0] code);
    return {~code[DATA_W-1], code[DATA_W-2:0]};
  endfunction

  assign tap_o   = offset_tap(data_i);
  assign stage_o = stage_for(mode_i);

endmodule

// File: rtl/dac_frontend.sv
module dac_frontend
  import dac_fe_pkg::*;
#(
  parameter  int FRAME_W     = 24,
  parameter  int DATA_W      = 16,
  parameter  int SYNC_STAGES = 2,
  localparam int KEEP_W      = DATA_W + PM_W,
  localparam int CNT_W       = $clog2(FRAME_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_n_i,
  input  logic              sclk_i,
  input  logic              din_i,
  output logic [DATA_W-1:0] tap_o,
  output logic [PM_W-1:0]   pmode_o,
  output logic              drive_en_o,
  output logic              pull_1k_o,
  output logic              pull_100k_o,
  output logic              hiz_o,
  output logic              update_o
);

  logic [2:0]        pins_now;
  logic              sync_fall_w, sync_rise_w, sclk_fall_w;
  logic              frame_done_w, abort_w;
  logic [KEEP_W-1:0] frame_word_w;
  logic [CNT_W-1:0]  bit_cnt_w;
  rx_state_e         rx_state_w;
  logic [DATA_W-1:0] data_w;
  pmode_e            mode_w;
  ostage_t           stage_w;

  dac_fe_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pins_i ({sync_n_i, sclk_i, din_i}),
    .now_o  (pins_now)
  );

  dac_fe_rx #(.FRAME_W(FRAME_W), .KEEP_W(KEEP_W)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_n_i    (pins_now[2]),
    .sclk_i      (pins_now[1]),
    .din_i       (pins_now[0]),
    .sync_fall_o (sync_fall_w),
    .sync_rise_o (sync_rise_w),
    .sclk_fall_o (sclk_fall_w),
    .done_o      (frame_done_w),
    .abort_o     (abort_w),
    .word_o      (frame_word_w),
    .cnt_o       (bit_cnt_w),
    .state_o     (rx_state_w)
  );

  dac_fe_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (frame_done_w),
    .word_i   (frame_word_w),
    .data_o   (data_w),
    .mode_o   (mode_w),
    .strobe_o (update_o)
  );

  dac_fe_outstage #(.DATA_W(DATA_W)) u_out (
    .data_i  (data_w),
    .mode_i  (mode_w),
    .tap_o   (tap_o),
    .stage_o (stage_w)
  );

  assign pmode_o     = mode_w;
  assign drive_en_o  = stage_w.drive;
  assign pull_1k_o   = stage_w.pull_lo;
  assign pull_100k_o = stage_w.pull_hi;
  assign hiz_o       = stage_w.open;

endmodule

// File: rtl/dac_frontend_chk.sv
module dac_frontend_chk
  import dac_fe_pkg::*;
#(
  parameter int FRAME_W = 24,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] tap,
  input logic [PM_W-1:0]   pmode,
  input logic              drive_en,
  input logic              pull_1k,
  input logic              pull_100k,
  input logic              hiz,
  input logic              update,
  input logic              frame_done,
  input logic              abort,
  input logic              sclk_fall,
  input logic [CNT_W-1:0]  bit_cnt,
  input rx_state_e         rx_state
);

  localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

  assert_reset_mid_R1: assert property (@(posedge clk)
    !rst_n |=> (tap == MID && pmode == 2'b00 && drive_en && !update));

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(FRAME_W));

  assert_done_then_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> update);

  assert_tap_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tap != $past(tap)) |-> update);

  assert_mode_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pmode != $past(pmode)) |-> update);

  assert_abort_no_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !update);

  assert_hold_ignores_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_state == RX_HOLD && sclk_fall) |=> !frame_done);

  assert_one_ctrl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({drive_en, pull_1k, pull_100k, hiz}) == 1);

  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    update |=> !update);

endmodule

bind dac_frontend dac_frontend_chk #(
  .FRAME_W (FRAME_W),
  .DATA_W  (DATA_W),
  .CNT_W   (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tap        (tap_o),
  .pmode      (pmode_o),
  .drive_en   (drive_en_o),
  .pull_1k    (pull_1k_o),
  .pull_100k  (pull_100k_o),
  .hiz        (hiz_o),
  .update     (update_o),
  .frame_done (frame_done_w),
  .abort      (abort_w),
  .sclk_fall  (sclk_fall_w),
  .bit_cnt    (bit_cnt_w),
  .rx_state   (rx_state_w)
);

// File: tb/dac_frontend_tb.sv
`timescale 1ns/1ps
module dac_frontend_tb;

  logic        clk = 1'b0;
  logic        rst_n, sync_n, sclk, din;
  logic [15:0] tap;
  logic [1:0]  pmode;
  logic        drive_en, pull_1k, pull_100k, hiz, update;

  int n_chk = 0, n_fail = 0, n_upd = 0;
  bit live = 0, finished = 0;

  always #2.5 clk = ~clk;

  dac_frontend u_dut (
    .clk(clk), .rst_n(rst_n), .sync_n_i(sync_n), .sclk_i(sclk), .din_i(din),
    .tap_o(tap), .pmode_o(pmode), .drive_en_o(drive_en), .pull_1k_o(pull_1k),
    .pull_100k_o(pull_100k), .hiz_o(hiz), .update_o(update)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: frame state from pins, outputs delayed 3 clocks.
  int m_state, m_cnt, m_acc, m_data, m_mode;
  bit m_upd, p_sync, p_sclk;
  int h_data[4], h_mode[4];
  bit h_upd[4];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_acc = 0; m_data = 0; m_mode = 0; m_upd = 0;
      p_sync = 1; p_sclk = 1;
      for (int i = 0; i < 4; i++) begin h_data[i] = 0; h_mode[i] = 0; h_upd[i] = 0; end
    end else begin
      m_upd = 0;
      if (m_state == 0) begin
        if (p_sync && !sync_n) begin m_state = 1; m_cnt = 0; m_acc = 0; end
      end else if (m_state == 1) begin
        if (!p_sync && sync_n) begin m_state = 0; m_cnt = 0; end
        else if (p_sclk && !sclk) begin
          m_acc = m_acc * 2 + int'(din);
          m_cnt++;
          if (m_cnt == 24) begin
            m_data = m_acc % 65536;
            m_mode = (m_acc / 65536) % 4;
            m_upd = 1;
            m_state = 2;
          end
        end
      end else begin
        if (!p_sync && sync_n) m_state = 0;
      end
      p_sync = sync_n; p_sclk = sclk;
      for (int i = 3; i > 0; i--) begin
        h_data[i] = h_data[i-1]; h_mode[i] = h_mode[i-1]; h_upd[i] = h_upd[i-1];
      end
      h_data[0] = m_data; h_mode[0] = m_mode; h_upd[0] = m_upd;
    end
  end

  always @(negedge clk) begin
    if (live && !finished) begin
      int et;
      et = (h_data[3] + 32768) % 65536;
      check(int'(tap) == et, "R3/R6 tap per cycle", tap, et);
      check(int'(pmode) == h_mode[3], "R3 mode per cycle", pmode, h_mode[3]);
      check({drive_en, pull_1k, pull_100k, hiz} ==
            {h_mode[3] == 0, h_mode[3] == 1, h_mode[3] == 2, h_mode[3] == 3},
            "R7 controls per cycle", {drive_en, pull_1k, pull_100k, hiz}, h_mode[3]);
      check(update == h_upd[3], "R8 strobe per cycle", update, h_upd[3]);
      if (update) n_upd++;
    end
  end

  task automatic send(input logic [23:0] w, input int nfall);
    @(negedge clk) sync_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nfall; i++) begin
      din = (i < 24) ? w[23-i] : 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
    end
    repeat (4) @(negedge clk);
    sync_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic expect_state(input int et, input int em, input int eu, input string tag);
    check(int'(tap) == et, {tag, " tap"}, tap, et);
    check(int'(pmode) == em, {tag, " mode"}, pmode, em);
    check(n_upd == eu, {tag, " strobe count"}, n_upd, eu);
  endtask

  initial begin
    rst_n = 1'b0; sync_n = 1'b1; sclk = 1'b1; din = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    live = 1;
    // R1 reset state
    check(tap == 16'h8000, "R1 reset tap", tap, 16'h8000);
    check(drive_en && !pull_1k && !pull_100k && !hiz, "R1 reset drive", drive_en, 1);
    expect_state(16'h8000, 0, 0, "R1 reset");
    // R2/R6: header bits ignored, mode 00, data 0x1234
    send({6'h3F, 2'b00, 16'h1234}, 24);
    expect_state(16'h9234, 0, 1, "R2 R6 frame");
    // R7: mode 01, most negative code
    send({6'h00, 2'b01, 16'h8000}, 24);
    expect_state(16'h0000, 1, 2, "R7 light pulldown");
    check(pull_1k, "R7 pull_1k", pull_1k, 1);
    // R7: mode 10, most positive code
    send({6'h15, 2'b10, 16'h7FFF}, 24);
    expect_state(16'hFFFF, 2, 3, "R7 weak pulldown");
    check(pull_100k, "R7 pull_100k", pull_100k, 1);
    // R4: aborted at 23 edges, then bare sync pulse
    send({6'h00, 2'b11, 16'h0000}, 23);
    expect_state(16'hFFFF, 2, 3, "R4 abort 23");
    send(24'h000000, 0);
    expect_state(16'hFFFF, 2, 3, "R4 abort 0");
    // R9: power-down frame still loads data
    send({6'h00, 2'b11, 16'h0001}, 24);
    expect_state(16'h8001, 3, 4, "R9 open with data");
    check(hiz && !drive_en, "R9 hiz", hiz, 1);
    // R5: six extra edges of ones after completion ignored
    send({6'h2A, 2'b00, 16'h4000}, 30);
    expect_state(16'hC000, 0, 5, "R5 extra edges");
    // R5: a new frame after sync high works
    send({6'h00, 2'b01, 16'hFFFF}, 24);
    expect_state(16'h7FFF, 1, 6, "R5 next frame");
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule